// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Load Interface

This block is the digital front end for two 12-bit converter channels that are fed from an 8-bit parallel processor bus. Each channel has two staging registers and one 12-bit output register. The low staging register holds the eight least significant bits. The high staging register holds the four most significant bits. Software fills the staging registers one byte at a time. An update access then copies the staging contents of both channels into their output registers in the same clock cycle, so that both converters move together.

The bus strobes are asynchronous to the system clock. Each combined strobe passes through a chain of synchronizer flops. A register acts once per strobe, on the leading edge of the combined strobe. The address and data lines must stay stable while the strobe is low. A separate active-low clear line empties every staging and output register at once and does not wait for a clock edge. The codes pass through without change, so straight-binary and offset-binary use are both possible downstream.

Top module: `dacif_dual_top`

## Requirements
- R1: After synchronous reset `rst`, both output codes read 0 and `out_load` is 0.
- R2: A write access (`cs_n`=0 and `wr_n`=0) is steered by `adr`. `adr[1]` selects the channel (0 = channel A, 1 = channel B). `adr[0]` selects the byte (0 = low eight bits, 1 = high four bits).
- R3: In a high write only `bus_d[3:0]` is stored, as code bits 11..8. `bus_d[7:4]` is ignored. In a low write `bus_d[7:0]` becomes code bits 7..0.
- R4: Holding `wr_n` low while `cs_n` is high writes no staging register.
- R5: Output codes keep their values while staging registers are written. They change only on an update or a clear.
- R6: An update access (`upd_n`=0 and `wr_n`=0) copies the staging registers of both channels into both output registers in the same clock cycle. This happens whatever the values of `adr` and `cs_n`.
- R7: If `cs_n` is also low during an update, the addressed staging register takes `bus_d` in that same cycle, and its new value reaches the output register.
- R8: `clr_n`=0 clears all staging and output registers to 0 without a clock edge. An update after the clear therefore produces zero codes.
- R9: Each access acts once, on the leading edge of its combined strobe. Data that changes while the strobe is still held low is not captured.
- R10: `out_load` is high for exactly one clock cycle for each update access. It rises in the cycle in which the output codes take their new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Asynchronous clear of all registers, active low |
| bus_d | input | 8 | Parallel data bus |
| adr | input | 2 | Address: bit 1 selects the channel, bit 0 selects the byte |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| upd_n | input | 1 | Update strobe, active low, qualified by `wr_n` |
| dac_a | output | 12 | Channel A output code |
| dac_b | output | 12 | Channel B output code |
| out_load | output | 1 | One-cycle pulse marking an output update |

## Verification
The scoreboard flags any output change that it did not predict. A design that let staging writes leak through, or that moved one channel a cycle before the other, therefore shows up as an extra change or a split change. The bench also targets these cases:
- An update access with chip select high and an unrelated address. A design that gated the copy with the address would leave one channel stale.
- An update with chip select low, whose forwarded byte must reach the output. A design that copied the old staging value would show the previous code.
- A strobe held low while the data changes. A level-sensitive design would capture the late value.
- A clear pulse that falls and rises between two clock edges. A synchronous-only clear would miss it completely.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    localparam int BUS_W  = 8;
    localparam int CODE_W = 12;
    localparam int HI_W   = CODE_W - BUS_W;
    localparam int CH_N   = 2;
    localparam int CH_W   = (CH_N > 1) ? $clog2(CH_N) : 1;
    localparam int ADR_W  = CH_W + 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [BUS_W-1:0]  lo_t;
    typedef logic [HI_W-1:0]   hi_t;

    typedef enum logic {
        PART_LO = 1'b0,
        PART_HI = 1'b1
    } part_e;

    typedef struct packed {
        logic lo_en;
        logic hi_en;
        lo_t  data;
    } chan_wr_t;

    function automatic code_t join_code(input hi_t h, input lo_t l);
        return {h, l};
    endfunction

    function automatic hi_t take_nibble(input lo_t d);
        return d[HI_W-1:0];
    endfunction
endpackage

// File: rtl/dacif_sync_edge.sv
module dacif_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], level_in};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;

    // R9: one strobe yields a single-cycle event
    assert_one_shot_R9: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/dacif_decode.sv
module dacif_decode
    import dacif_pkg::*;
(
    input  logic                      wr_rise,
    input  logic [ADR_W-1:0]          adr,
    input  lo_t                       bus_d,
    output chan_wr_t [CH_N-1:0]       req
);
    always_comb begin
        for (int c = 0; c < CH_N; c++) begin
            req[c].data  = bus_d;
            req[c].lo_en = wr_rise && (adr[ADR_W-1:1] == CH_W'(c))
                           && (part_e'(adr[0]) == PART_LO);
            req[c].hi_en = wr_rise && (adr[ADR_W-1:1] == CH_W'(c))
                           && (part_e'(adr[0]) == PART_HI);
        end
    end
endmodule

// File: rtl/dacif_chan.sv
module dacif_chan
    import dacif_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_n,
    input  chan_wr_t req,
    input  logic     upd,
    output code_t    code
);
    lo_t lo_q, lo_d;
    hi_t hi_q, hi_d;

    always_comb begin
        lo_d = req.lo_en ? req.data : lo_q;
        hi_d = req.hi_en ? take_nibble(req.data) : hi_q;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            lo_q <= '0;
            hi_q <= '0;
            code <= '0;
        end else if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
            code <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
            if (upd)
                code <= join_code(hi_d, lo_d);
        end
    end

    // R5: without an update the output holds, unless a clear zeroed it
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !upd |=> (code == $past(code) || code == '0));

    // R8: while clear is low every register of the channel reads zero
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (code == '0 && lo_q == '0 && hi_q == '0));
endmodule

// File: rtl/dacif_dual_top.sv
module dacif_dual_top
    import dacif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic [BUS_W-1:0]  bus_d,
    input  logic [ADR_W-1:0]  adr,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              upd_n,
    output logic [CODE_W-1:0] dac_a,
    output logic [CODE_W-1:0] dac_b,
    output logic              out_load
);
    logic wr_lvl, upd_lvl;
    logic wr_rise, upd_rise;
    chan_wr_t [CH_N-1:0] req;
    code_t codes [CH_N];

    assign wr_lvl  = ~cs_n  & ~wr_n;
    assign upd_lvl = ~upd_n & ~wr_n;

    dacif_sync_edge #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst(rst), .level_in(wr_lvl), .rise(wr_rise)
    );

    dacif_sync_edge #(.STAGES(SYNC_STAGES)) u_upd_sync (
        .clk(clk), .rst(rst), .level_in(upd_lvl), .rise(upd_rise)
    );

    dacif_decode u_dec (
        .wr_rise(wr_rise), .adr(adr), .bus_d(bus_d), .req(req)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        dacif_chan u_ch (
            .clk(clk), .rst(rst), .clr_n(clr_n),
            .req(req[c]), .upd(upd_rise), .code(codes[c])
        );
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            out_load <= 1'b0;
        else if (rst)
            out_load <= 1'b0;
        else
            out_load <= upd_rise;
    end

    assign dac_a = codes[0];
    assign dac_b = codes[1];

    // R10: the load marker is a single-cycle pulse
    assert_load_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        out_load |=> !out_load);

    // R6: every update event is followed by the load marker
    assert_update_marks_R6: assert property (@(posedge clk) disable iff (rst || !clr_n)
        upd_rise |=> out_load);
endmodule

// File: tb/sim_dacif_dual_top.sv
`timescale 1ns/100ps
module sim_dacif_dual_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_n = 1'b1;
    logic [7:0]  bus_d = '0;
    logic [1:0]  adr = '0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        upd_n = 1'b1;
    logic [11:0] dac_a, dac_b;
    logic        out_load;

    always #2.5 clk = ~clk;

    dacif_dual_top u0 (
        .clk(clk), .rst(rst), .clr_n(clr_n), .bus_d(bus_d), .adr(adr),
        .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n),
        .dac_a(dac_a), .dac_b(dac_b), .out_load(out_load)
    );

    int total = 0;
    int bad = 0;
    int n_upd = 0;
    int n_load = 0;
    bit done = 0;

    logic [7:0]  m_lo [2];
    logic [3:0]  m_hi [2];
    logic [11:0] m_out [2];
    logic [23:0] sb_q [$];

    task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        if (a[0]) m_hi[a[1]] = d[3:0];
        else      m_lo[a[1]] = d;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input bit sel);
        if (sel) model_write(a, d);
        @(negedge clk);
        adr = a; bus_d = d; cs_n = !sel; upd_n = 1'b1; wr_n = 1'b0;
        repeat (6) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic bus_update(input bit sel, input logic [1:0] a, input logic [7:0] d);
        logic [11:0] na, nb;
        if (sel) model_write(a, d);
        na = {m_hi[0], m_lo[0]};
        nb = {m_hi[1], m_lo[1]};
        if (na != m_out[0] || nb != m_out[1]) sb_q.push_back({na, nb});
        m_out[0] = na; m_out[1] = nb;
        n_upd++;
        @(negedge clk);
        adr = a; bus_d = d; cs_n = !sel; upd_n = 1'b0; wr_n = 1'b0;
        repeat (6) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1; upd_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // monitor: every output change must match the next predicted pair
    initial begin
        logic [11:0] pa, pb;
        logic [23:0] e;
        pa = '0; pb = '0;
        forever begin
            @(negedge clk);
            if (out_load) n_load++;
            if (!rst && (dac_a !== pa || dac_b !== pb)) begin
                total++;
                if (sb_q.size() == 0) begin
                    bad++;
                    $display("FAIL R5/R6: unexpected change got=%h,%h expected=%h,%h",
                             dac_a, dac_b, pa, pb);
                end else begin
                    e = sb_q.pop_front();
                    if ({dac_a, dac_b} !== e) begin
                        bad++;
                        $display("FAIL R6: change got=%h,%h expected=%h,%h",
                                 dac_a, dac_b, e[23:12], e[11:0]);
                    end
                end
                pa = dac_a; pb = dac_b;
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_lo[i] = '0; m_hi[i] = '0; m_out[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 dac_a", dac_a, 12'h000);
        chk("R1 dac_b", dac_b, 12'h000);
        chk("R1 out_load", {11'b0, out_load}, 12'h000);

        // staging writes, upper nibble bits set to prove they are dropped
        bus_write(2'b00, 8'h34, 1);
        bus_write(2'b01, 8'hF2, 1);
        bus_write(2'b10, 8'hCD, 1);
        bus_write(2'b11, 8'h0A, 1);
        chk("R5 hold a", dac_a, 12'h000);
        chk("R5 hold b", dac_b, 12'h000);
        bus_update(0, 2'b11, 8'h00);
        chk("R3 dac_a", dac_a, 12'h234);
        chk("R6 dac_b", dac_b, 12'hACD);

        // write strobe without chip select
        bus_write(2'b00, 8'hFF, 0);
        bus_update(0, 2'b00, 8'h00);
        chk("R4 dac_a", dac_a, 12'h234);

        // update combined with a write to channel B high nibble
        bus_update(1, 2'b11, 8'h05);
        chk("R7 dac_b", dac_b, 12'h5CD);
        chk("R7 dac_a", dac_a, 12'h234);

        // data changes while the strobe is held low
        @(negedge clk);
        adr = 2'b00; bus_d = 8'h11; cs_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_d = 8'h99;
        repeat (4) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        repeat (6) @(negedge clk);
        m_lo[0] = 8'h11;
        bus_update(0, 2'b10, 8'h00);
        chk("R9 dac_a", dac_a, 12'h211);

        // clear pulse entirely between two clock edges
        sb_q.push_back(24'h0);
        for (int i = 0; i < 2; i++) begin
            m_lo[i] = '0; m_hi[i] = '0; m_out[i] = '0;
        end
        @(posedge clk);
        #0.5 clr_n = 1'b0;
        #1.0;
        chk("R8 async a", dac_a, 12'h000);
        chk("R8 async b", dac_b, 12'h000);
        #0.5 clr_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_update(0, 2'b00, 8'h00);
        chk("R8 staging cleared a", dac_a, 12'h000);
        chk("R8 staging cleared b", dac_b, 12'h000);

        // address map: channel A high, channel B low
        bus_write(2'b01, 8'h07, 1);
        bus_write(2'b10, 8'hEE, 1);
        bus_update(0, 2'b01, 8'h00);
        chk("R2 dac_a", dac_a, 12'h700);
        chk("R2 dac_b", dac_b, 12'h0EE);

        repeat (4) @(negedge clk);
        chk("R10 pulses", 12'(n_load), 12'(n_upd));
        chk("R6 queue empty", 12'(sb_q.size()), 12'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule